// File: doc/BRIEF.md
# Level-Sensitive Two-Output Interrupt Aggregator

This block gathers 32 level-sensitive interrupt request lines and presents them to a processor as two interrupt outputs. Each request line passes through a two-flop synchronizer. The synchronized line is then masked by a per-source enable bit and assigned to one of the two outputs by a per-source routing bit. The top bit of the enable word also acts as a master gate, and both outputs stay low while it is clear.

Software reaches the block over a plain 32-bit register bus, made up of a byte address, a write strobe, write data and combinational read data. The enable word has no direct write path. A write to the set address turns on the enable bits written as 1. A write to the clear address turns off the enable bits written as 1. Reading either of these two addresses returns the current enable word.

Software can read a pending word for each output, and a raw word that shows the synchronized line levels before masking. To pick the source to service, software takes the lowest-numbered bit that is set in a pending word. Because the sources are level-sensitive, a source stays pending for as long as its line is high and it is enabled. Nothing is latched beyond that.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset, the enable word and the routing word are 0, both `cpu_irq` bits are 0, and every readable address returns 0.
- R2: A write to address 0x34 sets each enable bit whose written bit is 1. All other enable bits keep their value.
- R3: A write to address 0x38 clears each enable bit whose written bit is 1. Writing all ones clears the whole enable word.
- R4: A read of address 0x34 returns the enable word, and a read of address 0x38 returns the same word.
- R5: Address 0x20 holds the routing word, which reads back as written. Routing bit i = 0 assigns source i to output 0, and routing bit i = 1 assigns it to output 1.
- R6: Address 0x30 reads the synchronized `irq_in` levels whatever the enable bits hold. A change on `irq_in` first shows up there after two rising clock edges.
- R7: Address 0x00 reads raw AND enable AND NOT routing. Address 0x04 reads raw AND enable AND routing.
- R8: While enable bit 31 (the master gate) is 0, both `cpu_irq` bits are 0, even when a pending word is nonzero.
- R9: `cpu_irq[n]` is a register. On each rising edge it loads the OR of pending word n ANDed with the master gate, so it lags the pending word by one edge.
- R10: A source stays pending while its line is high. After its line falls, it leaves raw status two edges later and its `cpu_irq` bit drops one edge after that.
- R11: Writes to addresses other than 0x20, 0x34 and 0x38 change no state. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | Level-sensitive request lines, asynchronous to clk |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| cpu_irq | output | 2 | Interrupt outputs to the processor |

## Verification
The bench writes the set register a second time and checks that the first bit survives. A design that loaded the enable word directly instead of ORing into it would lose that bit.

It holds a pending source while the master gate is off. A controller that ignored bit 31 would raise `cpu_irq` at that point. It also checks one cycle either side of each output change. This catches a design whose synchronizer is missing a stage or whose output flop is missing.

It moves one source to output 1 and checks that output 0 is unaffected. A design that inverted the meaning of the routing bit would swap the two outputs. Finally, it writes all ones to the raw-status address and reads an unmapped offset. This exposes address decoding that is too loose.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;

  // Byte offsets of the register map
  localparam int OFS_PEND0  = 'h00;
  localparam int OFS_PEND1  = 'h04;
  localparam int OFS_ROUTE  = 'h20;
  localparam int OFS_RAW    = 'h30;
  localparam int OFS_EN_SET = 'h34;
  localparam int OFS_EN_CLR = 'h38;

  // Pending word for one output: raw & enable & route selector
  function automatic logic [31:0] pend_word(input logic [31:0] raw,
                                            input logic [31:0] en,
                                            input logic [31:0] route,
                                            input logic        sel);
    return raw & en & (sel ? route : ~route);
  endfunction

  // Next enable word after a set/clear access
  function automatic logic [31:0] en_next(input logic [31:0] cur,
                                          input logic [31:0] data,
                                          input logic        do_set,
                                          input logic        do_clr);
    logic [31:0] v;
    v = cur;
    if (do_set) v = v | data;
    if (do_clr) v = v & ~data;
    return v;
  endfunction

endpackage

// File: rtl/lvl_irq_sync.sv
module lvl_irq_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= async_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];

  // R6: the output only takes values that were present one stage earlier
  a_r6_chain : assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> sync_out == $past(stage_q[STAGES-2 < 0 ? 0 : STAGES-2]));
endmodule

// File: rtl/lvl_irq_regs.sv
module lvl_irq_regs
  import lvl_irq_pkg::*;
#(
  parameter int N  = 32,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic [N-1:0]  wdata,
  output logic [N-1:0]  en_vec,
  output logic [N-1:0]  route_vec,
  output logic          glb_en
);
  localparam int GLB_BIT = N - 1;

  logic hit_set, hit_clr, hit_route;
  assign hit_set   = wr && (addr == AW'(OFS_EN_SET));
  assign hit_clr   = wr && (addr == AW'(OFS_EN_CLR));
  assign hit_route = wr && (addr == AW'(OFS_ROUTE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_vec    <= '0;
      route_vec <= '0;
    end else begin
      en_vec <= N'(en_next(32'(en_vec), 32'(wdata), hit_set, hit_clr));
      if (hit_route) route_vec <= wdata;
    end
  end

  assign glb_en = en_vec[GLB_BIT];

  // R2: after a set access every written 1 is enabled
  a_r2_set_bits : assert property (@(posedge clk) disable iff (!rst_n)
    hit_set |=> (en_vec & $past(wdata)) == $past(wdata));
  // R2: a set access never clears a bit
  a_r2_set_keeps : assert property (@(posedge clk) disable iff (!rst_n)
    hit_set |=> (en_vec & $past(en_vec)) == $past(en_vec));
  // R3: after a clear access every written 1 is disabled
  a_r3_clr_bits : assert property (@(posedge clk) disable iff (!rst_n)
    hit_clr |=> (en_vec & $past(wdata)) == '0);
  // R5/R11: the routing word is held without a routing write
  a_r5_route_hold : assert property (@(posedge clk) disable iff (!rst_n)
    !hit_route |=> $stable(route_vec));
  // R11: the enable word only moves on set/clear accesses
  a_r11_en_hold : assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_set || hit_clr) |=> $stable(en_vec));
endmodule

// File: rtl/lvl_irq_route.sv
module lvl_irq_route
  import lvl_irq_pkg::*;
#(
  parameter int N    = 32,
  parameter int OUTS = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N-1:0]             raw,
  input  logic [N-1:0]             en_vec,
  input  logic [N-1:0]             route_vec,
  input  logic                     glb_en,
  output logic [OUTS-1:0][N-1:0]   pend,
  output logic [OUTS-1:0]          irq_q
);
  for (genvar g = 0; g < OUTS; g++) begin : g_out
    logic want;
    assign pend[g] = N'(pend_word(32'(raw), 32'(en_vec), 32'(route_vec), g[0]));
    assign want    = (|pend[g]) && glb_en;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q[g] <= 1'b0;
      else        irq_q[g] <= want;
    end

    // R9: a gated nonzero pending word raises the output on the next edge
    a_r9_rise : assert property (@(posedge clk) disable iff (!rst_n)
      ((|pend[g]) && glb_en) |=> irq_q[g]);
    // R8: with the master gate off, the output is low on the next edge
    a_r8_gate : assert property (@(posedge clk) disable iff (!rst_n)
      !glb_en |=> !irq_q[g]);
    // R7: pending bits are a subset of raw and enable
    a_r7_subset : assert property (@(posedge clk) disable iff (!rst_n)
      (pend[g] & ~(raw & en_vec)) == '0);
  end
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
  import lvl_irq_pkg::*;
#(
  parameter int N        = 32,
  parameter int AW       = 8,
  parameter int SYNC_STG = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  irq_in,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [N-1:0]  bus_wdata,
  output logic [N-1:0]  bus_rdata,
  output logic [1:0]    cpu_irq
);
  localparam int OUTS = 2;

  logic [N-1:0]            raw_lvl;
  logic [N-1:0]            en_vec;
  logic [N-1:0]            route_vec;
  logic                    glb_en;
  logic [OUTS-1:0][N-1:0]  pend;
  logic [OUTS-1:0]         irq_q;

  lvl_irq_sync #(.W(N), .STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(irq_in), .sync_out(raw_lvl));

  lvl_irq_regs #(.N(N), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr),
    .wdata(bus_wdata), .en_vec(en_vec), .route_vec(route_vec),
    .glb_en(glb_en));

  lvl_irq_route #(.N(N), .OUTS(OUTS)) u_route (
    .clk(clk), .rst_n(rst_n), .raw(raw_lvl), .en_vec(en_vec),
    .route_vec(route_vec), .glb_en(glb_en), .pend(pend), .irq_q(irq_q));

  always_comb begin
    case (bus_addr)
      AW'(OFS_PEND0):  bus_rdata = pend[0];
      AW'(OFS_PEND1):  bus_rdata = pend[1];
      AW'(OFS_ROUTE):  bus_rdata = route_vec;
      AW'(OFS_RAW):    bus_rdata = raw_lvl;
      AW'(OFS_EN_SET): bus_rdata = en_vec;
      AW'(OFS_EN_CLR): bus_rdata = en_vec;
      default:         bus_rdata = '0;
    endcase
  end

  assign cpu_irq = irq_q;

  // R7: the two pending words never claim the same source
  a_r7_disjoint : assert property (@(posedge clk) disable iff (!rst_n)
    (pend[0] & pend[1]) == '0);
  // R1: outputs are low on the first edge after reset
  a_r1_out_low : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> cpu_irq == 2'b00);
endmodule

// File: tb/lvl_irq_ctrl_test.sv
module lvl_irq_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] irq_in = '0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  cpu_irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       req;
  } exp_t;
  exp_t exp_q[$];
  event mon_ev;

  lvl_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cpu_irq(cpu_irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  // Monitor: pops expected items and compares with the design
  initial begin
    forever begin
      @(mon_ev);
      while (exp_q.size() > 0) begin
        exp_t it;
        logic [31:0] got;
        it  = exp_q.pop_front();
        got = it.is_irq ? {30'd0, cpu_irq} : bus_rdata;
        checks++;
        if (got !== it.exp) begin
          fails++;
          $display("FAIL %s got=%h exp=%h", it.req, got, it.exp);
        end
      end
    end
  end

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic exp_reg(input logic [7:0] a, input logic [31:0] e, input string r);
    exp_t it;
    bus_addr = a;
    #1;
    it.is_irq = 0; it.exp = e; it.req = r;
    exp_q.push_back(it);
    -> mon_ev;
    #1;
  endtask

  task automatic exp_irq(input logic [1:0] e, input string r);
    exp_t it;
    #1;
    it.is_irq = 1; it.exp = {30'd0, e}; it.req = r;
    exp_q.push_back(it);
    -> mon_ev;
    #1;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    // R1: reset state
    exp_reg(8'h00, 32'h0, "R1");
    exp_reg(8'h04, 32'h0, "R1");
    exp_reg(8'h20, 32'h0, "R1");
    exp_reg(8'h30, 32'h0, "R1");
    exp_reg(8'h34, 32'h0, "R1");
    exp_irq(2'b00, "R1");

    // R6: raw visible after two edges, regardless of enables
    irq_in = 32'h0000_0005;
    step(1);
    exp_reg(8'h30, 32'h0, "R6");
    step(1);
    exp_reg(8'h30, 32'h0000_0005, "R6");
    exp_reg(8'h00, 32'h0, "R7");

    // R2/R4: set accumulates, both addresses read the word
    wr_reg(8'h34, 32'h0000_0001);
    wr_reg(8'h34, 32'h0000_0100);
    exp_reg(8'h34, 32'h0000_0101, "R2");
    exp_reg(8'h38, 32'h0000_0101, "R4");
    exp_reg(8'h00, 32'h0000_0001, "R7");
    step(1);
    exp_irq(2'b00, "R8");

    // R9: master gate on, output one edge after the write
    wr_reg(8'h34, 32'h8000_0000);
    exp_irq(2'b00, "R9");
    step(1);
    exp_irq(2'b01, "R9");

    // R5: route source 2 to output 1
    wr_reg(8'h20, 32'h0000_0004);
    exp_reg(8'h20, 32'h0000_0004, "R5");
    wr_reg(8'h34, 32'h0000_0004);
    exp_reg(8'h04, 32'h0000_0004, "R5");
    exp_reg(8'h00, 32'h0000_0001, "R5");
    step(1);
    exp_irq(2'b11, "R5");

    // R3: clear source 0
    wr_reg(8'h38, 32'h0000_0001);
    exp_reg(8'h34, 32'h8000_0104, "R3");
    exp_reg(8'h00, 32'h0, "R3");
    step(1);
    exp_irq(2'b10, "R3");

    // R10: line 2 falls; raw after two edges, output after three
    irq_in = 32'h0000_0001;
    step(2);
    exp_reg(8'h30, 32'h0000_0001, "R10");
    exp_irq(2'b10, "R10");
    step(1);
    exp_irq(2'b00, "R10");

    // R11: write to raw ignored, unmapped reads zero
    wr_reg(8'h30, 32'hFFFF_FFFF);
    wr_reg(8'h00, 32'hFFFF_FFFF);
    exp_reg(8'h30, 32'h0000_0001, "R11");
    exp_reg(8'h34, 32'h8000_0104, "R11");
    exp_reg(8'h20, 32'h0000_0004, "R11");
    exp_reg(8'h10, 32'h0, "R11");

    // R3: clear all
    wr_reg(8'h38, 32'hFFFF_FFFF);
    exp_reg(8'h38, 32'h0, "R3");
    step(1);
    exp_irq(2'b00, "R3");

    // R8: pending without master gate keeps outputs low
    wr_reg(8'h20, 32'h0);
    wr_reg(8'h34, 32'h0000_0001);
    exp_reg(8'h00, 32'h0000_0001, "R8");
    step(2);
    exp_irq(2'b00, "R8");

    step(1);
    done = 1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog got=timeout exp=done");
    end
    #2;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule